// File: doc/BRIEF.md
# Shared-Sense-Amplifier Bank Arbiter

This block holds the open/closed state of a row of DRAM banks that are stacked as stripes, with each pair of neighbouring banks sharing one set of sense amplifiers. Because of that sharing, a bank can only be opened while both of its immediate neighbours are closed. A controller presents one request per slot: an opcode (open a row, close it, or access a column) and a bank number. The arbiter decides whether the request is legal and answers one cycle later with exactly one of three flags: granted, refused because of a neighbour (conflict), or invalid for the bank's own state (error).

A granted open or close updates the per-bank state vector in the same cycle that the grant flag is seen. A granted column access raises the two column-bank enable lines that border the accessed bank for that one cycle. There are one more enable lines than banks: line k sits between bank k-1 and bank k. Bank 0 and the last bank each have a single neighbour, and the stack does not wrap around.

Top module: `dbank_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, every bank reads closed, `col_en` is zero and no response flag is high; `req_ready` is low in reset and high from the first clock edge after reset is released.
- R2: An activate (`req_op` = 2'b01) to a closed bank whose neighbours are both closed raises `rsp_grant` in the cycle after acceptance, and the bank's `bank_open` bit is set in that same cycle.
- R3: An activate (2'b01) to a closed bank with bank n-1 or bank n+1 open raises `rsp_conflict` for one cycle and leaves `bank_open` unchanged; two adjacent banks are never open together.
- R4: Bank 0 is checked only against bank 1, and the last bank only against the one below it; an open last bank does not block bank 0.
- R5: An activate (2'b01) to a bank already open raises `rsp_error` and leaves `bank_open` unchanged.
- R6: A precharge (2'b10) to an open bank is granted and clears its bit; an activate to a neighbour presented in the very next slot is then granted.
- R7: A precharge (2'b10) to a closed bank raises `rsp_error` and leaves `bank_open` unchanged.
- R8: A column access (2'b11) to an open bank b is granted, and in the grant cycle `col_en` has exactly bits b and b+1 set; in every other cycle `col_en` is zero.
- R9: A column access (2'b11) to a closed bank raises `rsp_error`, keeps `col_en` zero and leaves `bank_open` unchanged.
- R10: Opcode 2'b00 is not a valid request: it raises `rsp_error` and changes nothing.
- R11: Each accepted request (`req_valid` and `req_ready` high at a clock edge) produces exactly one of `rsp_grant`, `rsp_conflict`, `rsp_error` for one cycle after that edge; a cycle with no accepted request produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this slot |
| req_ready | output | 1 | Arbiter accepts a request this slot |
| req_op | input | 2 | 01 activate, 10 precharge, 11 column access, 00 invalid |
| req_bank | input | 4 | Target bank index |
| rsp_grant | output | 1 | Previous request granted |
| rsp_conflict | output | 1 | Previous request refused by a neighbour lock |
| rsp_error | output | 1 | Previous request illegal for the bank's own state |
| bank_open | output | 16 | One bit per bank, 1 = open |
| col_en | output | 17 | Column-bank enable lines, line k between bank k-1 and bank k |

## Verification
The interesting overlap is a precharge that releases a lock and the adjacency check of the request that follows it in the next slot: the bench issues a precharge of bank 3 and an activate of bank 4 back to back with no idle slot, and expects the activate to be granted, not refused. A second overlap is the response flag and the state update landing on the same edge, so a conflict or error must show the state exactly as it was before. A behavioural model in the bench computes every flag, the state vector and the enable lines each cycle, and the outputs are compared against it on every clock through directed edge cases and a long random stream.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_PRE  = 2'b10,
    OP_COL  = 2'b11
  } dbank_op_e;

  typedef enum logic [1:0] {
    RSP_NONE     = 2'b00,
    RSP_GRANT    = 2'b01,
    RSP_CONFLICT = 2'b10,
    RSP_ERROR    = 2'b11
  } dbank_rsp_e;

endpackage

// File: rtl/dbank_rules.sv
module dbank_rules
  import dbank_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 accept,
  input  dbank_op_e            op,
  input  logic [BANK_W-1:0]    bank,
  input  logic [NUM_BANKS-1:0] open_vec,
  output dbank_rsp_e           rsp,
  output logic [NUM_BANKS-1:0] set_vec,
  output logic [NUM_BANKS-1:0] clr_vec,
  output logic                 col_fire
);

  logic [NUM_BANKS-1:0] sel;
  logic [NUM_BANKS-1:0] lock;
  logic                 tgt_open;
  logic                 tgt_lock;

  // one-hot bank select and per-bank neighbour lock; edges have one neighbour
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign sel[i] = (bank == BANK_W'(i));
    if (i == 0) begin : g_low
      assign lock[i] = open_vec[1];
    end else if (i == NUM_BANKS - 1) begin : g_high
      assign lock[i] = open_vec[NUM_BANKS-2];
    end else begin : g_mid
      assign lock[i] = open_vec[i-1] | open_vec[i+1];
    end
  end

  assign tgt_open = |(sel & open_vec);
  assign tgt_lock = |(sel & lock);

  always_comb begin
    rsp      = RSP_NONE;
    set_vec  = '0;
    clr_vec  = '0;
    col_fire = 1'b0;
    if (accept) begin
      unique case (op)
        OP_ACT: begin
          if (tgt_open) begin
            rsp = RSP_ERROR;
          end else if (tgt_lock) begin
            rsp = RSP_CONFLICT;
          end else begin
            rsp     = RSP_GRANT;
            set_vec = sel;
          end
        end
        OP_PRE: begin
          if (tgt_open) begin
            rsp     = RSP_GRANT;
            clr_vec = sel;
          end else begin
            rsp = RSP_ERROR;
          end
        end
        OP_COL: begin
          if (tgt_open) begin
            rsp      = RSP_GRANT;
            col_fire = 1'b1;
          end else begin
            rsp = RSP_ERROR;
          end
        end
        default: rsp = RSP_ERROR;
      endcase
    end
  end

endmodule

// File: rtl/dbank_state.sv
module dbank_state #(
  parameter int NUM_BANKS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] set_vec,
  input  logic [NUM_BANKS-1:0] clr_vec,
  output logic [NUM_BANKS-1:0] open_vec
);

  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] open_d;
  logic [NUM_BANKS-1:0] open_en;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_flop
    assign open_en[i] = set_vec[i] | clr_vec[i];
    assign open_d[i]  = set_vec[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[i] <= 1'b0;
      end else if (open_en[i]) begin
        open_q[i] <= open_d[i];
      end
    end
  end

  assign open_vec = open_q;

  AST_NO_ADJ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q & (open_q >> 1)) == '0); // R3

  AST_SET_CLOSED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec & open_q) == '0); // R5

  AST_CLR_OPEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec & ~open_q) == '0); // R7

  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec | clr_vec)); // R11

endmodule

// File: rtl/dbank_colsel.sv
module dbank_colsel #(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int LINES  = NUM_BANKS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BANK_W-1:0] bank,
  output logic [LINES-1:0]  col_en
);

  logic [LINES-1:0] col_d;
  logic [LINES-1:0] col_q;

  // line k borders bank k-1 (below) and bank k (above)
  for (genvar k = 0; k < LINES; k++) begin : g_line
    if (k == 0) begin : g_first
      assign col_d[k] = fire && (bank == BANK_W'(0));
    end else if (k == LINES - 1) begin : g_last
      assign col_d[k] = fire && (bank == BANK_W'(k-1));
    end else begin : g_inner
      assign col_d[k] = fire && ((bank == BANK_W'(k)) || (bank == BANK_W'(k-1)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else begin
      col_q <= col_d;
    end
  end

  assign col_en = col_q;

  AST_COL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_q) |-> ($countones(col_q) == 2)); // R8

  AST_COL_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_q) |-> ((col_q & (col_q >> 1)) != '0)); // R8

endmodule

// File: rtl/dbank_arbiter.sv
module dbank_arbiter
  import dbank_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [BANK_W-1:0]    req_bank,
  output logic                 rsp_grant,
  output logic                 rsp_conflict,
  output logic                 rsp_error,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS:0]   col_en
);

  logic                 ready_q;
  logic                 accept;
  dbank_rsp_e           rsp_d;
  dbank_rsp_e           rsp_q;
  logic [NUM_BANKS-1:0] set_vec;
  logic [NUM_BANKS-1:0] clr_vec;
  logic                 col_fire;
  logic [NUM_BANKS-1:0] open_vec;

  assign accept = req_valid && ready_q;

  dbank_rules #(.NUM_BANKS(NUM_BANKS)) i_rules (
    .accept   (accept),
    .op       (dbank_op_e'(req_op)),
    .bank     (req_bank),
    .open_vec (open_vec),
    .rsp      (rsp_d),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .col_fire (col_fire)
  );

  dbank_state #(.NUM_BANKS(NUM_BANKS)) i_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .open_vec (open_vec)
  );

  dbank_colsel #(.NUM_BANKS(NUM_BANKS)) i_colsel (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (col_fire),
    .bank   (req_bank),
    .col_en (col_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      rsp_q   <= RSP_NONE;
    end else begin
      ready_q <= 1'b1;
      rsp_q   <= rsp_d;
    end
  end

  assign req_ready    = ready_q;
  assign bank_open    = open_vec;
  assign rsp_grant    = (rsp_q == RSP_GRANT);
  assign rsp_conflict = (rsp_q == RSP_CONFLICT);
  assign rsp_error    = (rsp_q == RSP_ERROR);

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_grant, rsp_conflict, rsp_error})); // R11

  AST_NO_REQ_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_ready) |-> !(rsp_grant || rsp_conflict || rsp_error)); // R11

  AST_OPEN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_open & ~$past(bank_open)) != '0) |-> rsp_grant); // R2

  AST_CONFLICT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_conflict |-> $stable(bank_open)); // R3

  AST_ERROR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> $stable(bank_open)); // R5

  AST_COL_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_en) |-> (rsp_grant && $stable(bank_open))); // R8

endmodule

// File: tb/test_dbank_arbiter.sv
module test_dbank_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 16;
  localparam int WATCHDOG   = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [3:0]    req_bank = 4'd0;
  logic          rsp_grant, rsp_conflict, rsp_error;
  logic [NB-1:0] bank_open;
  logic [NB:0]   col_en;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  dbank_arbiter i_dbank_arbiter (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_bank     (req_bank),
    .rsp_grant    (rsp_grant),
    .rsp_conflict (rsp_conflict),
    .rsp_error    (rsp_error),
    .bank_open    (bank_open),
    .col_en       (col_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit          m_open [NB];
  bit          m_ready;
  bit          m_grant, m_conf, m_err;
  logic [NB:0] m_col;
  string       m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_open[i]) m_open[i] = 1'b0;
      m_ready = 1'b0; m_grant = 1'b0; m_conf = 1'b0; m_err = 1'b0;
      m_col = '0; m_tag = "R1";
    end else begin
      int b;
      bit lk;
      m_grant = 1'b0; m_conf = 1'b0; m_err = 1'b0; m_col = '0;
      if (m_tag != "R1" || m_ready) m_tag = "R11";
      if (req_valid && m_ready) begin
        b = int'(req_bank);
        case (req_op)
          2'b01: begin
            lk = (b > 0 && m_open[b-1]) || (b < NB-1 && m_open[b+1]);
            if (m_open[b]) begin m_err = 1'b1; m_tag = "R5"; end
            else if (lk) begin
              m_conf = 1'b1;
              m_tag = (b == 0 || b == NB-1) ? "R4" : "R3";
            end else begin
              m_grant = 1'b1; m_open[b] = 1'b1;
              m_tag = (b == 0 || b == NB-1) ? "R4" : "R2";
            end
          end
          2'b10: begin
            if (m_open[b]) begin m_grant = 1'b1; m_open[b] = 1'b0; m_tag = "R6"; end
            else begin m_err = 1'b1; m_tag = "R7"; end
          end
          2'b11: begin
            if (m_open[b]) begin m_grant = 1'b1; m_col[b] = 1'b1; m_col[b+1] = 1'b1; m_tag = "R8"; end
            else begin m_err = 1'b1; m_tag = "R9"; end
          end
          default: begin m_err = 1'b1; m_tag = "R10"; end
        endcase
      end
      m_ready = 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NB:0] act, input logic [NB:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, half a period after the active edge
  always @(negedge clk) begin
    logic [NB-1:0] ov;
    for (int i = 0; i < NB; i++) ov[i] = m_open[i];
    check(req_ready === m_ready, "R1", "req_ready", {16'd0, req_ready}, {16'd0, m_ready});
    check(rsp_grant === m_grant, m_tag, "rsp_grant", {16'd0, rsp_grant}, {16'd0, m_grant});
    check(rsp_conflict === m_conf, m_tag, "rsp_conflict", {16'd0, rsp_conflict}, {16'd0, m_conf});
    check(rsp_error === m_err, m_tag, "rsp_error", {16'd0, rsp_error}, {16'd0, m_err});
    check(bank_open === ov, m_tag, "bank_open", {1'b0, bank_open}, {1'b0, ov});
    check(col_en === m_col, (m_tag == "R9") ? "R9" : "R8", "col_en", col_en, m_col);
  end

  task automatic issue(input logic [1:0] op, input int bank);
    req_valid = 1'b1;
    req_op    = op;
    req_bank  = 4'(bank);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);   // R1: reset state compared each cycle
    rst_n = 1'b1;
    @(negedge clk);
    idle(2);
    issue(2'b01, 3);    // R2 grant
    issue(2'b01, 2);    // R3 conflict below
    issue(2'b01, 4);    // R3 conflict above
    issue(2'b01, 3);    // R5 already open
    issue(2'b11, 3);    // R8 lines 3 and 4
    issue(2'b11, 5);    // R9 closed bank
    issue(2'b10, 3);    // R6 precharge
    issue(2'b01, 4);    // R6 neighbour in next slot
    issue(2'b10, 4);
    issue(2'b10, 4);    // R7 already closed
    issue(2'b01, 0);    // R4 edge low
    issue(2'b01, 1);    // R4 blocked by bank 0
    issue(2'b01, 15);   // R4 no wrap-around
    issue(2'b01, 14);   // R4 blocked by bank 15
    issue(2'b11, 15);   // R8 lines 15 and 16
    issue(2'b11, 0);    // R8 lines 0 and 1
    issue(2'b00, 7);    // R10 invalid opcode
    idle(3);            // R11 no request, no response
    issue(2'b01, 7);
    idle(1);
    issue(2'b11, 7);
    for (int n = 0; n < 4000; n++) begin
      req_valid = ($urandom_range(0, 3) != 0);
      req_op    = 2'($urandom_range(0, 3));
      req_bank  = 4'($urandom_range(0, NB-1));
      @(negedge clk);
    end
    idle(3);
    summary();
  end

endmodule